// File: doc/BRIEF.md
# UART Transmit Queue with Low-Water Flag

This block sits between a register bus and a UART serial shifter. Software writes bytes into a queue whose depth it selects at run time. The shifter pulls bytes from the head of the queue through a ready/valid handshake. A latched low-water flag tells software when the queue has drained to a programmed watermark or below. A completion flag tells it when the queue is empty and the line is idle. Either flag can raise a level interrupt.

The watermark comparison uses only the words still waiting in the queue. A byte that the shifter has accepted no longer counts. The low-water flag is sticky. Software clears it by reading status while the flag reads 1 and then writing a data byte. If the queue is still at or below the watermark after that write, the flag is set again at once. So only a write that lifts the level above the watermark leaves it clear.

The bus has four registers, selected by `bus_addr`:
- 0, status. Reading it returns low-water in bit 7, completion in bit 6 and overflow in bit 0. Writing it with bit 0 set clears overflow.
- 1, data. A write pushes one byte.
- 2, watermark. Eight bits, readable and writable.
- 3, control. Bit 0 is the queue enable, bits 3:1 the size code, bit 4 a write-only flush strobe, bit 5 the low-water interrupt enable and bit 6 the completion interrupt enable.

Top module: `uart_txq_wm`

## Requirements
- R1: After reset the queue is empty and `tx_valid` and `irq` are 0. Status reads 0xC0 (low-water and completion set, overflow clear), and watermark and control read 0.
- R2: Bytes reach `tx_data` in the order they were written. The head word is removed in a cycle where `tx_valid` and `tx_ready` are both 1.
- R3: With the enable bit clear the depth is 1 word. With it set, size code 0 gives 1 word, code k from 1 to 6 gives 2^(k+1) words (code 6 gives 128), and code 7 is clipped to 128.
- R4: The low-water flag becomes 1 whenever the queued count, which excludes bytes already accepted by the shifter, is less than or equal to the watermark. Once 1 it stays 1 until the clear sequence.
- R5: A status read that returns low-water = 1 arms the clear. The next data write clears the flag only if the count after that write is above the watermark; otherwise the flag still reads 1.
- R6: A data write with no armed status read before it leaves the low-water flag unchanged.
- R7: A watermark value not less than the selected depth is ignored, and the low-water flag is then held at 1.
- R8: A data write to a full queue is discarded and sets overflow (status bit 0). Overflow stays set until status is written with bit 0 = 1.
- R9: Writing control with bit 4 = 1, or with an enable or size value that differs from the current one, empties the queue.
- R10: The completion flag (status bit 6) is 1 only while the queue is empty, `tx_busy` is 0 and no byte is being handed over.
- R11: `irq` is registered. It equals (low-water AND control bit 5) OR (completion AND control bit 6), one cycle after those flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| tx_data | output | 8 | Head byte offered to the shifter |
| tx_valid | output | 1 | Queue holds at least one byte |
| tx_ready | input | 1 | Shifter takes the head byte |
| tx_busy | input | 1 | Shifter has a character in flight |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume one bus access per cycle, which makes a data write and a control or status access mutually exclusive. They also assume that a size or enable change is paired with the flush it triggers. The completion property further assumes the shifter raises `tx_busy` in the cycle after it accepts a byte. The stimulus issues every bus access as a single strobed cycle followed by an idle cycle. It pulses `tx_ready` only in cycles with no bus access, and changes `tx_busy` only between accesses, so a reference model updated once per cycle stays aligned with the design.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
  localparam int BW = 8;
  localparam logic [1:0] A_STAT  = 2'd0;
  localparam logic [1:0] A_DATA  = 2'd1;
  localparam logic [1:0] A_WATER = 2'd2;
  localparam logic [1:0] A_CTRL  = 2'd3;
  localparam int B_EN    = 0;
  localparam int B_FLUSH = 4;
  localparam int B_IE_LW = 5;
  localparam int B_IE_TC = 6;

  // depth in words for an enable bit and size code, clipped to 2**aw
  function automatic int unsigned depth_sel(logic en, logic [2:0] code, int unsigned aw);
    int unsigned sh;
    if (!en || code == 3'd0) return 1;
    sh = int'(code) + 1;
    if (sh > aw) sh = aw;
    return 32'd1 << sh;
  endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int WORD_W    = 8,
  parameter int MAX_DEPTH = 128
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(MAX_DEPTH):0]  depth,
  input  logic                        push,
  input  logic [WORD_W-1:0]           push_data,
  input  logic                        pop_req,
  input  logic                        flush,
  output logic [$clog2(MAX_DEPTH):0]  cnt,
  output logic [$clog2(MAX_DEPTH):0]  cnt_next,
  output logic                        full,
  output logic                        pop_ok,
  output logic [WORD_W-1:0]           head
);
  localparam int AW = $clog2(MAX_DEPTH);
  localparam int CW = AW + 1;

  logic [WORD_W-1:0] mem [MAX_DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt_q;
  logic              push_ok;

  function automatic logic [AW-1:0] step_ptr(logic [AW-1:0] p, logic [CW-1:0] d);
    return (CW'(p) == d - CW'(1)) ? '0 : p + AW'(1);
  endfunction

  assign full     = (cnt_q == depth);
  assign push_ok  = push & ~full & ~flush;
  assign pop_ok   = pop_req & (cnt_q != '0) & ~flush;
  assign cnt_next = flush ? '0 : cnt_q + CW'(push_ok) - CW'(pop_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_next;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok) wr_ptr <= step_ptr(wr_ptr, depth);
        if (pop_ok)  rd_ptr <= step_ptr(rd_ptr, depth);
      end
    end
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  assign head = mem[rd_ptr];
  assign cnt  = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= depth);                                                  // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop_ok) |=> cnt_q == $past(cnt_q));             // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> cnt_q == '0);                                           // R9
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int CW = 8,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_next,
  input  logic [CW-1:0] depth,
  input  logic [WW-1:0] water,
  input  logic          stat_rd,
  input  logic          data_wr,
  input  logic          pop,
  input  logic          tx_busy,
  input  logic          ovf_set,
  input  logic          ovf_clr,
  input  logic          ie_lw,
  input  logic          ie_tc,
  output logic          lwf,
  output logic          tcf,
  output logic          ovf,
  output logic          irq
);
  localparam int MW = (CW > WW) ? CW : WW;

  logic armed_q, water_bad, below_n, clr;

  assign water_bad = MW'(water) >= MW'(depth);
  assign below_n   = water_bad | (MW'(cnt_next) <= MW'(water));
  assign clr       = data_wr & armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lwf     <= 1'b1;
      tcf     <= 1'b1;
      ovf     <= 1'b0;
      armed_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      lwf <= (lwf & ~clr) | below_n;
      if (data_wr)            armed_q <= 1'b0;
      else if (stat_rd && lwf) armed_q <= 1'b1;
      tcf <= (cnt_next == '0) & ~tx_busy & ~pop;
      ovf <= (ovf & ~ovf_clr) | ovf_set;
      irq <= (lwf & ie_lw) | (tcf & ie_tc);
    end
  end

  AST_LWF_AT_LOW: assert property (@(posedge clk) disable iff (rst)
    ((MW'(cnt) <= MW'(water) || MW'(water) >= MW'(depth)) && $stable(water) && $stable(depth))
      |-> lwf);                                                       // R4
  AST_LWF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (lwf && !(data_wr && armed_q)) |=> lwf);                          // R6
  AST_LWF_CLR_ARMED: assert property (@(posedge clk) disable iff (rst)
    $fell(lwf) |-> $past(data_wr && armed_q));                        // R5
  AST_TCF_EMPTY: assert property (@(posedge clk) disable iff (rst)
    tcf |-> cnt == '0);                                               // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);                                       // R8
endmodule

// File: rtl/uart_txq_wm.sv
module uart_txq_wm
  import uart_txq_pkg::*;
#(
  parameter int MAX_DEPTH = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic [BW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic          tx_busy,
  output logic          irq
);
  localparam int AW = $clog2(MAX_DEPTH);
  localparam int CW = AW + 1;

  logic [BW-1:0] water_q, rdata_q;
  logic          en_q, ie_lw_q, ie_tc_q;
  logic [2:0]    size_q;
  logic          wr, rd, stat_rd, data_wr, water_wr, ctrl_wr, ovf_clr;
  logic          cfg_change, flush, full, pop_ok;
  logic [CW-1:0] depth, cnt, cnt_next;
  logic          lwf, tcf, ovf;

  assign wr       = bus_sel & bus_we;
  assign rd       = bus_sel & ~bus_we;
  assign stat_rd  = rd & (bus_addr == A_STAT);
  assign data_wr  = wr & (bus_addr == A_DATA);
  assign water_wr = wr & (bus_addr == A_WATER);
  assign ctrl_wr  = wr & (bus_addr == A_CTRL);
  assign ovf_clr  = wr & (bus_addr == A_STAT) & bus_wdata[0];

  assign cfg_change = (bus_wdata[B_EN] != en_q) || (bus_wdata[3:1] != size_q);
  assign flush      = ctrl_wr & (bus_wdata[B_FLUSH] | cfg_change);
  assign depth      = CW'(depth_sel(en_q, size_q, AW));

  always_ff @(posedge clk) begin
    if (rst) begin
      water_q <= '0;
      en_q    <= 1'b0;
      size_q  <= '0;
      ie_lw_q <= 1'b0;
      ie_tc_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (water_wr) water_q <= bus_wdata;
      if (ctrl_wr) begin
        en_q    <= bus_wdata[B_EN];
        size_q  <= bus_wdata[3:1];
        ie_lw_q <= bus_wdata[B_IE_LW];
        ie_tc_q <= bus_wdata[B_IE_TC];
      end
      if (rd) begin
        unique case (bus_addr)
          A_STAT:  rdata_q <= {lwf, tcf, 5'b0, ovf};
          A_WATER: rdata_q <= water_q;
          A_CTRL:  rdata_q <= {1'b0, ie_tc_q, ie_lw_q, 1'b0, size_q, en_q};
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  txq_store #(.WORD_W(BW), .MAX_DEPTH(MAX_DEPTH)) u_store (
    .clk, .rst, .depth,
    .push(data_wr), .push_data(bus_wdata),
    .pop_req(tx_ready), .flush,
    .cnt, .cnt_next, .full, .pop_ok, .head(tx_data)
  );

  txq_flags #(.CW(CW), .WW(BW)) u_flags (
    .clk, .rst, .cnt, .cnt_next, .depth, .water(water_q),
    .stat_rd, .data_wr, .pop(pop_ok), .tx_busy,
    .ovf_set(data_wr & full), .ovf_clr,
    .ie_lw(ie_lw_q), .ie_tc(ie_tc_q),
    .lwf, .tcf, .ovf, .irq
  );

  assign tx_valid  = (cnt != '0);
  assign bus_rdata = rdata_q;

  AST_POP_ORDER: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !flush) |=> cnt == $past(cnt) - CW'(1) + CW'($past(data_wr && !full))); // R2
endmodule

// File: tb/test_uart_txq_wm.sv
`timescale 1ns/1ps
module test_uart_txq_wm;
  import uart_txq_pkg::*;

  logic clk = 0, rst = 1, sel = 0, we = 0, ready = 0, busy = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, txd;
  logic txv, irq;

  always #2 clk = ~clk;

  uart_txq_wm i_uart_txq_wm (
    .clk, .rst, .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .tx_data(txd), .tx_valid(txv), .tx_ready(ready),
    .tx_busy(busy), .irq
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [7:0] m_buf [128];
  int m_head, m_cnt;
  logic [7:0] m_water;
  logic m_en, m_lw, m_tc, m_ovf, m_armed, m_ielw, m_ietc;
  logic [2:0] m_size;

  function automatic int m_depth();
    if (!m_en || m_size == 0) return 1;
    if (m_size >= 6) return 128;
    return 1 << (int'(m_size) + 1);
  endfunction

  function automatic bit m_below(int c);
    return (int'(m_water) >= m_depth()) || (c <= int'(m_water));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit clr, bit popping);
    m_lw = (m_lw & ~clr) | m_below(m_cnt);
    m_tc = (m_cnt == 0) & ~busy & ~popping;
  endtask

  task automatic idle_upd();
    m_lw = m_lw | m_below(m_cnt);
    m_tc = (m_cnt == 0) & ~busy;
  endtask

  task automatic cyc_bus(logic w, logic [1:0] a, logic [7:0] d);
    @(negedge clk); sel = 1; we = w; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic do_write(logic [7:0] b);
    bit clr, full;
    full = (m_cnt == m_depth());
    cyc_bus(1, A_DATA, b);
    clr = m_armed; m_armed = 0;
    if (full) m_ovf = 1;
    else begin m_buf[(m_head + m_cnt) % 128] = b; m_cnt++; end
    step(clr, 0);
    idle_upd();
  endtask

  task automatic do_stat(string tag);
    logic [7:0] exp;
    exp = {m_lw, m_tc, 5'b0, m_ovf};
    cyc_bus(0, A_STAT, 0);
    if (m_lw) m_armed = 1;
    step(0, 0);
    idle_upd();
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic do_read(logic [1:0] a, logic [7:0] exp, string tag);
    cyc_bus(0, a, 0);
    step(0, 0);
    idle_upd();
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic do_pop(string tag);
    @(negedge clk);
    chk(txv == (m_cnt != 0), {tag, " valid"}, txv, m_cnt != 0);
    if (m_cnt != 0) chk(txd == m_buf[m_head], {tag, " data"}, txd, m_buf[m_head]);
    ready = 1;
    @(negedge clk); ready = 0;
    if (m_cnt != 0) begin
      m_head = (m_head + 1) % 128; m_cnt--;
      step(0, 1);
    end else step(0, 0);
    idle_upd();
  endtask

  task automatic do_water(logic [7:0] w);
    cyc_bus(1, A_WATER, w);
    step(0, 0);
    m_water = w;
    idle_upd();
  endtask

  task automatic do_ctrl(bit en, logic [2:0] sz, bit fl, bit ielw, bit ietc);
    bit f;
    f = fl || (en != m_en) || (sz != m_size);
    cyc_bus(1, A_CTRL, {1'b0, ietc, ielw, fl, sz, en});
    if (f) begin m_cnt = 0; m_head = 0; end
    step(0, 0);
    m_en = en; m_size = sz; m_ielw = ielw; m_ietc = ietc;
    idle_upd();
  endtask

  task automatic do_ovfclr();
    cyc_bus(1, A_STAT, 8'h01);
    m_ovf = 0;
    step(0, 0);
    idle_upd();
  endtask

  task automatic set_busy(bit v);
    busy = v;
    @(negedge clk);
    idle_upd();
  endtask

  task automatic chk_irq(string tag);
    bit exp;
    repeat (2) begin @(negedge clk); idle_upd(); end
    exp = (m_lw & m_ielw) | (m_tc & m_ietc);
    chk(irq == exp, tag, irq, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r;
    m_head = 0; m_cnt = 0; m_water = 0; m_en = 0; m_size = 0;
    m_lw = 1; m_tc = 1; m_ovf = 0; m_armed = 0; m_ielw = 0; m_ietc = 0;
    r = $urandom(32'd24681);
    repeat (4) @(negedge clk);
    rst = 0;
    idle_upd();

    // R1 reset state
    chk(txv == 0, "R1 tx_valid", txv, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    do_stat("R1 status");
    do_read(A_WATER, 8'h00, "R1 water");
    do_read(A_CTRL, 8'h00, "R1 ctrl");

    // R3 disabled queue holds one word; R8 overflow
    do_write(8'h11);
    do_write(8'h22);
    do_stat("R8 ovf set");
    do_pop("R2 single");
    do_pop("R3 depth1 empty");
    do_ovfclr();
    do_stat("R8 ovf clear");

    // R3 depth 4 fill and order
    do_ctrl(1, 3'd1, 0, 0, 0);
    for (int i = 0; i < 5; i++) do_write(8'hA1 + 8'(i));
    do_stat("R3 depth4 ovf");
    for (int i = 0; i < 4; i++) do_pop("R2 order");
    do_ovfclr();

    // R4 R5 R6 clear sequence against watermark 1
    do_water(8'd1);
    do_write(8'h31); do_write(8'h32); do_write(8'h33);
    do_stat("R6 unarmed writes keep flag");
    do_pop("R2 pop"); do_pop("R2 pop"); do_pop("R2 pop");
    do_write(8'h34); do_write(8'h35);
    do_stat("R5 arm");
    do_write(8'h36);
    do_stat("R5 cleared above water");
    do_write(8'h37);
    do_stat("R6 write without arm");
    do_pop("R2 pop"); do_pop("R2 pop");
    do_stat("R4 reassert at water");
    do_ctrl(1, 3'd1, 1, 0, 0);
    do_stat("R5 arm empty");
    do_write(8'h41);
    do_stat("R5 stays set at water");

    // R7 watermark beyond depth
    do_water(8'd9);
    do_write(8'h42); do_write(8'h43);
    do_stat("R7 arm");
    do_write(8'h44);
    do_stat("R7 flag held");

    // R9 flush
    do_ctrl(1, 3'd1, 1, 0, 0);
    do_pop("R9 flushed");
    do_stat("R9 status");
    do_write(8'h51);
    do_ctrl(1, 3'd2, 0, 0, 0);
    do_pop("R9 size change flush");

    // R10 R11 completion and interrupt
    do_ctrl(1, 3'd2, 0, 0, 1);
    chk_irq("R11 tc irq");
    set_busy(1);
    do_stat("R10 busy");
    chk_irq("R11 tc irq busy");
    set_busy(0);
    do_stat("R10 idle");
    do_write(8'h61);
    do_stat("R10 queued");
    do_water(8'd0);
    do_ctrl(1, 3'd2, 0, 1, 0);
    do_write(8'h62);
    do_stat("R11 arm");
    do_write(8'h63);
    chk_irq("R11 lw irq low");
    do_ctrl(1, 3'd2, 1, 1, 0);
    chk_irq("R11 lw irq high");

    // R3 code 6 and code 7 give 128
    do_ctrl(1, 3'd6, 0, 0, 0);
    for (int i = 0; i < 129; i++) do_write(8'(i));
    do_stat("R3 depth128 ovf");
    do_ovfclr();
    do_ctrl(1, 3'd7, 0, 0, 0);
    for (int i = 0; i < 128; i++) do_write(8'(i * 3));
    do_stat("R3 code7 no ovf");
    do_write(8'hFF);
    do_stat("R3 code7 ovf");
    do_pop("R2 deep head");

    // constrained random mix
    do_ctrl(1, 3'd1, 1, 0, 0);
    do_ovfclr();
    for (int k = 0; k < 600; k++) begin
      r = int'($urandom_range(0, 99));
      if (r < 40)      do_write(8'($urandom));
      else if (r < 62) do_stat("R4 R5 random status");
      else if (r < 90) do_pop("R2 random pop");
      else if (r < 95) do_water(8'($urandom_range(0, 9)));
      else if (r < 98) do_ctrl(1'($urandom), 3'($urandom_range(0, 3)), 1'($urandom), 0, 0);
      else             do_ovfclr();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule